// File: doc/BRIEF.md
# Continuous Single-Channel A/D Conversion Sequencer

This block is the digital control side of a successive-approximation A/D converter that runs one analog input over and over under software control. Software writes a mode register and a channel register. Once the enable bit is set and the mode field selects continuous single-channel operation, the sequencer starts the converter. It sends the chosen channel number and a one-cycle start strobe to the external converter. It then waits for the converter's done pulse and result word.

Each finished result goes into the result register that belongs to the converted channel. In the same cycle, a one-cycle interrupt pulse is raised. The sequencer then starts the next conversion of that channel on its own. The loop stops only when software clears the enable bit. A write to either register while a conversion is under way cancels that conversion and starts a fresh one. The cancelled conversion leaves no result and raises no interrupt.

Top module: `adc_cont_seq`

## Requirements
- R1: Writing the mode register (wr_sel=0) with enable bit 7 set and mode field bits 1:0 equal to 00 starts a conversion. cnv_start is high for one cycle in the cycle after the write, and cnv_chan equals the channel register.
- R2: mode_rd bit 6 (busy) reads 1 while conversions run. After a write that clears the enable bit, busy reads 0 from the next cycle on, and no further cnv_start is issued.
- R3: A write to either register while a conversion is in progress abandons that conversion. cnv_start is issued again in the next cycle, and the abandoned conversion writes no result and raises no irq.
- R4: The channel register (wr_sel=1) takes wr_data bits 2:0. A result is written only to the result register numbered by the channel that was converted, and every other result register keeps its value.
- R5: irq is a one-cycle pulse for each completed conversion. It is high in the first cycle in which the new result can be read through rd_chan/rd_data.
- R6: After each completed conversion the next one starts with no software action: cnv_start is high in the same cycle as irq.
- R7: A result register that is not read before the next conversion of its channel completes is overwritten with the newer value.
- R8: With the enable bit set but a mode field other than 00, no conversion starts and busy stays 0.
- R9: After reset, mode_rd reads 0, chan_rd reads 0, irq is 0 and every result register reads 0. Reading a result register has no side effect.
- R10: A channel-register write while stopped only updates chan_rd. It starts no conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the mode register, 1 selects the channel register |
| wr_data | input | 8 | Write data |
| mode_rd | output | 8 | Mode readback: bit 7 enable, bit 6 busy, bits 1:0 mode field |
| chan_rd | output | 3 | Channel register readback |
| rd_chan | input | 3 | Result register index to read |
| rd_data | output | 12 | Contents of the indexed result register |
| cnv_chan | output | 3 | Channel presented to the converter |
| cnv_start | output | 1 | One-cycle start strobe to the converter |
| cnv_done | input | 1 | Converter finished pulse |
| cnv_data | input | 12 | Converter result, valid with cnv_done |
| irq | output | 1 | Conversion-end interrupt pulse |

## Verification
The bench aims register writes at the waiting phase of a conversion and checks that a fresh start strobe follows at once. It also checks that the abandoned result never shows up. A design that let the stale done through would raise an interrupt with no matching scoreboard entry, or would write the previous channel's register.

The channel is changed mid-run, then the bench confirms that each channel's register holds only its own latest value. This catches a sequencer that writes to the wrong index or that fails to overwrite. A non-zero mode field and a channel write while stopped must both leave the converter untouched, and disabling must clear busy in the next cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int MODE_EN_BIT   = 7;
    localparam int MODE_BUSY_BIT = 6;

    typedef enum logic [1:0] {
        MD_CONT_SELECT = 2'b00,
        MD_RSVD1       = 2'b01,
        MD_RSVD2       = 2'b10,
        MD_RSVD3       = 2'b11
    } mode_field_e;

    typedef struct packed {
        logic        en;
        mode_field_e md;
    } mode_reg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_WAIT
    } seq_state_e;

    function automatic logic runs(input mode_reg_t m);
        return m.en && (m.md == MD_CONT_SELECT);
    endfunction

    function automatic logic [7:0] pack_mode(input mode_reg_t m, input logic busy);
        logic [7:0] w;
        w = '0;
        w[MODE_EN_BIT]   = m.en;
        w[MODE_BUSY_BIT] = busy;
        w[1:0]           = m.md;
        return w;
    endfunction

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [7:0]      wr_data,
    output mode_reg_t       mode_q,
    output logic [CH_W-1:0] chan_q,
    output logic            run_q,
    output logic            run_d
);

    mode_reg_t mode_w;
    logic      mode_wr;

    assign mode_wr   = wr_en && !wr_sel;
    assign mode_w.en = wr_data[MODE_EN_BIT];
    assign mode_w.md = mode_field_e'(wr_data[1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            chan_q <= '0;
        end else if (wr_en) begin
            if (wr_sel) chan_q <= wr_data[CH_W-1:0];
            else        mode_q <= mode_w;
        end
    end

    assign run_q = runs(mode_q);
    assign run_d = mode_wr ? runs(mode_w) : run_q;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run_d,
    input  logic wr_en,
    input  logic cnv_done,
    output logic cnv_start,
    output logic busy,
    output logic commit,
    output logic irq
);

    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        if (!run_d) begin
            state_d = ST_IDLE;
        end else if (wr_en) begin
            state_d = ST_START;
        end else begin
            case (state_q)
                ST_IDLE:  state_d = ST_START;
                ST_START: state_d = ST_WAIT;
                ST_WAIT: begin
                    if (cnv_done) begin
                        commit  = 1'b1;
                        state_d = ST_START;
                    end
                end
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            irq     <= 1'b0;
        end else begin
            state_q <= state_d;
            irq     <= commit;
        end
    end

    assign cnv_start = (state_q == ST_START);
    assign busy      = (state_q != ST_IDLE);

    AST_RESTART_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && run_d) |=> cnv_start); // R3
    AST_NO_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !irq); // R3
    AST_IDLE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
        !run_d |=> (!busy && !cnv_start)); // R2
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R5
    AST_IRQ_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        irq |-> cnv_start); // R6

endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results #(
    parameter int CH_W  = 3,
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  logic [CH_W-1:0]  wr_chan,
    input  logic [RES_W-1:0] wr_val,
    input  logic [CH_W-1:0]  rd_chan,
    output logic [RES_W-1:0] rd_data
);

    localparam int NUM_CH = 1 << CH_W;

    logic [RES_W-1:0] res_q [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)                                         res_q[i] <= '0;
            else if (commit && (wr_chan == CH_W'(i)))        res_q[i] <= wr_val;
        end

        AST_OTHER_CH_STABLE: assert property (@(posedge clk) disable iff (rst)
            !(commit && (wr_chan == CH_W'(i))) |=> $stable(res_q[i])); // R4
    end

    assign rd_data = res_q[rd_chan];

endmodule

// File: rtl/adc_cont_seq.sv
module adc_cont_seq
    import adc_seq_pkg::*;
#(
    parameter int CH_W  = 3,
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [7:0]       wr_data,
    output logic [7:0]       mode_rd,
    output logic [CH_W-1:0]  chan_rd,
    input  logic [CH_W-1:0]  rd_chan,
    output logic [RES_W-1:0] rd_data,
    output logic [CH_W-1:0]  cnv_chan,
    output logic             cnv_start,
    input  logic             cnv_done,
    input  logic [RES_W-1:0] cnv_data,
    output logic             irq
);

    mode_reg_t       mode_q;
    logic [CH_W-1:0] chan_q;
    logic            run_q, run_d, busy, commit;

    adc_seq_regs #(.CH_W(CH_W)) u_regs (
        .clk, .rst, .wr_en, .wr_sel, .wr_data,
        .mode_q, .chan_q, .run_q, .run_d
    );

    adc_seq_ctrl u_ctrl (
        .clk, .rst, .run_d, .wr_en, .cnv_done,
        .cnv_start, .busy, .commit, .irq
    );

    adc_seq_results #(.CH_W(CH_W), .RES_W(RES_W)) u_res (
        .clk, .rst, .commit, .wr_chan(chan_q), .wr_val(cnv_data),
        .rd_chan, .rd_data
    );

    assign mode_rd  = pack_mode(mode_q, busy);
    assign chan_rd  = chan_q;
    assign cnv_chan = chan_q;

    AST_START_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        cnv_start |-> run_q); // R1
    AST_BAD_MODE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (mode_q.md != MD_CONT_SELECT) |-> !busy); // R8

endmodule

// File: tb/adc_cont_seq_tb.sv
`timescale 1ns/1ps
module adc_cont_seq_tb;

    localparam int CH_W = 3;
    localparam int RES_W = 12;
    localparam int LAT = 6;

    logic clk = 0, rst = 1;
    logic wr_en = 0, wr_sel = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] mode_rd;
    logic [CH_W-1:0] chan_rd, rd_chan = 0, cnv_chan;
    logic [RES_W-1:0] rd_data, cnv_data;
    logic cnv_start, cnv_done, irq;

    int checks = 0, fails = 0, irq_cnt = 0, start_cnt = 0;
    bit finished = 0;
    logic [RES_W-1:0] exp_q [$];
    logic [RES_W-1:0] last_val [8];

    always #5 clk = ~clk;

    adc_cont_seq #(.CH_W(CH_W), .RES_W(RES_W)) u_dut (
        .clk, .rst, .wr_en, .wr_sel, .wr_data, .mode_rd, .chan_rd,
        .rd_chan, .rd_data, .cnv_chan, .cnv_start, .cnv_done, .cnv_data, .irq
    );

    // Converter stub: fixed latency, restarts on every start strobe
    int stub_cnt;
    logic [CH_W-1:0] stub_chan;
    logic [8:0] stub_seq;
    always @(posedge clk) begin
        if (rst) begin
            stub_cnt <= 0; cnv_done <= 0; cnv_data <= 0; stub_seq <= 1; stub_chan <= 0;
        end else if (cnv_start) begin
            stub_cnt <= LAT; stub_chan <= cnv_chan; cnv_done <= 0;
        end else if (stub_cnt != 0) begin
            stub_cnt <= stub_cnt - 1;
            if (stub_cnt == 1) begin
                cnv_done <= 1;
                cnv_data <= {stub_chan, stub_seq};
                stub_seq <= stub_seq + 1;
            end
        end else begin
            cnv_done <= 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard: push on accepted done, pop and compare on irq
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            if (cnv_start) start_cnt++;
            if (cnv_done && !wr_en && mode_rd[6] && !cnv_start)
                exp_q.push_back(cnv_data);
            if (irq) begin
                logic [RES_W-1:0] e;
                irq_cnt++;
                check(cnv_start, "R6 restart with irq", cnv_start, 1);
                if (exp_q.size() == 0) begin
                    check(0, "R3/R5 irq without completed conversion", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    rd_chan = e[RES_W-1 -: CH_W];
                    #1;
                    check(rd_data == e, "R5/R4 result at irq", rd_data, e);
                    last_val[e[RES_W-1 -: CH_W]] = e;
                end
            end
        end
    end

    task automatic wr(input bit sel, input logic [7:0] d);
        @(negedge clk); #1;
        wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk); #1;
        wr_en = 0;
    endtask

    task automatic wait_irqs(input int n);
        int target = irq_cnt + n;
        for (int i = 0; i < 5000 && irq_cnt < target; i++) @(negedge clk);
        #3;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int s0, i0;
        for (int c = 0; c < 8; c++) last_val[c] = 0;
        repeat (4) @(posedge clk);
        rst = 0;
        @(negedge clk); #1;
        // R9 reset state
        check(mode_rd == 0, "R9 mode reset", mode_rd, 0);
        check(chan_rd == 0, "R9 chan reset", chan_rd, 0);
        check(irq == 0, "R9 irq reset", irq, 0);
        for (int c = 0; c < 8; c++) begin
            rd_chan = c[CH_W-1:0]; #1;
            check(rd_data == 0, "R9 result reset", rd_data, 0);
        end
        // R10 channel write while stopped
        s0 = start_cnt;
        wr(1, 8'h02);
        repeat (5) @(negedge clk); #3;
        check(chan_rd == 2, "R10 chan written", chan_rd, 2);
        check(start_cnt == s0 && mode_rd[6] == 0, "R10 no start when stopped", start_cnt - s0, 0);
        // R8 non-zero mode field
        wr(0, 8'h81);
        repeat (20) @(negedge clk); #3;
        check(start_cnt == s0, "R8 no start in other mode", start_cnt - s0, 0);
        check(mode_rd == 8'h81, "R8 busy stays 0", mode_rd, 8'h81);
        // R1 start
        wr(0, 8'h80);
        check(cnv_start && cnv_chan == 2, "R1 start strobe on ch2", {cnv_start, cnv_chan}, 4'hA);
        check(mode_rd[6] == 1, "R2 busy while running", mode_rd[6], 1);
        i0 = irq_cnt;
        wait_irqs(4);
        check(irq_cnt - i0 >= 4, "R6 repeats without re-arm", irq_cnt - i0, 4);
        // R3 channel write in WAIT aborts
        @(posedge cnv_start); @(negedge clk); @(negedge clk);
        i0 = irq_cnt;
        wr(1, 8'h05);
        check(cnv_start && cnv_chan == 5, "R3 restart after chan write", {cnv_start, cnv_chan}, 4'hD);
        check(irq_cnt == i0, "R3 no irq for aborted", irq_cnt - i0, 0);
        wait_irqs(3);
        // R3 mode rewrite in WAIT aborts
        @(posedge cnv_start); @(negedge clk); @(negedge clk); @(negedge clk);
        i0 = irq_cnt;
        wr(0, 8'h80);
        check(cnv_start == 1, "R3 restart after mode write", cnv_start, 1);
        wait_irqs(2);
        // R2 stop
        wr(0, 8'h00);
        check(mode_rd[6] == 0 && cnv_start == 0, "R2 busy clears on stop", mode_rd, 0);
        s0 = start_cnt; i0 = irq_cnt;
        repeat (3 * LAT) @(negedge clk); #3;
        check(start_cnt == s0 && irq_cnt == i0, "R2 no activity after stop", start_cnt - s0, 0);
        check(exp_q.size() == 0, "R5 every conversion raised irq", exp_q.size(), 0);
        // R4 / R7 / R9: each register holds its own latest value, reads repeatable
        for (int c = 0; c < 8; c++) begin
            rd_chan = c[CH_W-1:0]; #1;
            check(rd_data == last_val[c], "R4/R7 per-channel latest", rd_data, last_val[c]);
            #1;
            check(rd_data == last_val[c], "R9 read no side effect", rd_data, last_val[c]);
        end
        check(last_val[2] != 0 && last_val[5] != 0, "R4 both channels written", last_val[2], 1);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule